// File: doc/BRIEF.md
# Recency-Ordered Instruction Word Cache

This block is a small, fully associative, read-only cache that sits beside a 32-bit fetch stage. Each entry holds one instruction word and the full word address it came from. The entries are kept in a chain of registers. An entry's place in the chain is its recency: stage 0 is the most recently used entry and stage `DEPTH-1` is the least recently used. No age counters or age bits exist anywhere.

The fetch stage presents a lookup address. In the same cycle the block reports whether the address hit and returns the stored word. When a lookup misses, the fetch logic gets the word from memory and hands it back through the fill port. The fill is placed at the top of the chain, every entry moves down one stage, and the bottom entry is dropped. A lookup hit at stage k moves that entry to the top and shifts down only the entries that were above it. The entries below k stay where they are.

Cached words are never compared against memory again. If memory changes after a word has been cached, the cache keeps returning the stale word.

Top module: `shiftlru_icache`

## Requirements
- R1: A synchronous reset clears every stage's valid bit. After reset, no lookup hits until a fill has been made.
- R2: When `lk_vld_i` is high and a valid stage holds a tag equal to `lk_addr_i`, `hit_o` is 1 and `insn_o` carries that stage's word in the same cycle. On a miss, `insn_o` is 0.
- R3: A fill with `fill_vld_i` high whose address is in no valid stage writes {address, data} into stage 0 at the next edge. Each stage k takes the old content of stage k-1, and the old content of stage `DEPTH-1` is lost.
- R4: A lookup hit at stage k>0, with no fill in that cycle, writes the hit entry into stage 0 at the next edge. Stages 1..k take the old content of the stage above them, and stages k+1..`DEPTH-1` keep their content.
- R5: A lookup hit at stage 0, with no fill in that cycle, leaves the whole chain unchanged.
- R6: A fill whose address already hits is handled as a recency move of that entry, following R4 and R5. The fill data is ignored, the stored word is kept, and a tag never appears in two valid stages.
- R7: While some stages are still invalid, a fill still shifts the whole chain and discards the invalid bottom entry. The number of valid stages never decreases, and the chain is full after `DEPTH` distinct fills.
- R8: When a fill and a lookup hit occur in the same cycle, only the fill updates the chain. The lookup outputs in that cycle still reflect the chain as it was before the edge.
- R9: While `lk_vld_i` is low, `hit_o` and `insn_o` are 0 and a lookup causes no recency move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_vld_i | input | 1 | Lookup request this cycle |
| lk_addr_i | input | AW | Lookup word address |
| fill_vld_i | input | 1 | Fill request this cycle |
| fill_addr_i | input | AW | Address of the word being filled |
| fill_data_i | input | DW | Instruction word being filled |
| hit_o | output | 1 | Lookup hit (combinational) |
| insn_o | output | DW | Word of the hitting stage, 0 on a miss |

## Verification
The bench builds the cache with `DEPTH=4` and 32-bit tags and words. A four-stage chain fills up within a few cycles, so the bench can reach the partly-filled, full and evicting states many times. It draws addresses from a pool of six. Because the pool is larger than the chain, random lookups and fills keep producing hits at every stage, hits at the top, fills of addresses already present, and evictions of the bottom entry. With a depth of four, the shift of only part of the chain (R4) can be seen at every possible hit position.

// File: rtl/lru_icache_pkg.sv
package lru_icache_pkg;

  // Kind of chain update applied at the coming clock edge
  typedef enum logic [1:0] {
    UPD_NONE    = 2'd0,
    UPD_REORDER = 2'd1,
    UPD_INSERT  = 2'd2
  } upd_e;

  function automatic int unsigned idx_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/lru_icache_stage.sv
module lru_icache_stage #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_i,
  input  logic          v_d_i,
  input  logic [AW-1:0] tag_d_i,
  input  logic [DW-1:0] data_d_i,
  output logic          v_q_o,
  output logic [AW-1:0] tag_q_o,
  output logic [DW-1:0] data_q_o
);

  // Valid bit is reset; payload registers are not, keeping them cheap
  always_ff @(posedge clk) begin
    if (rst) begin
      v_q_o <= 1'b0;
    end else if (en_i) begin
      v_q_o <= v_d_i;
    end
  end

  always_ff @(posedge clk) begin
    if (en_i) begin
      tag_q_o  <= tag_d_i;
      data_q_o <= data_d_i;
    end
  end

endmodule

// File: rtl/lru_icache_match.sv
module lru_icache_match #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  parameter int unsigned IDXW  = 3
) (
  input  logic [AW-1:0]             addr_i,
  input  logic [DEPTH-1:0]          v_i,
  input  logic [DEPTH-1:0][AW-1:0]  tag_i,
  input  logic [DEPTH-1:0][DW-1:0]  data_i,
  output logic [DEPTH-1:0]          match_o,
  output logic                      hit_o,
  output logic [IDXW-1:0]           idx_o,
  output logic [DW-1:0]             data_o
);

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_cmp
      assign match_o[k] = v_i[k] && (tag_i[k] == addr_i);
    end
  endgenerate

  assign hit_o = |match_o;

  // Tags are unique, so at most one match bit is set: an OR-based
  // encoder and AND-OR data mux are enough and keep logic shallow.
  always_comb begin
    idx_o  = '0;
    data_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (match_o[i]) begin
        idx_o  = idx_o | IDXW'(i);
        data_o = data_o | data_i[i];
      end
    end
  end

endmodule

// File: rtl/lru_icache_ctrl.sv
module lru_icache_ctrl
  import lru_icache_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned IDXW  = 3
) (
  input  logic             lk_vld_i,
  input  logic             lk_hit_i,
  input  logic [IDXW-1:0]  lk_idx_i,
  input  logic             fill_vld_i,
  input  logic             fill_hit_i,
  input  logic [IDXW-1:0]  fill_idx_i,
  output upd_e             upd_o,
  output logic [IDXW-1:0]  src_idx_o,
  output logic [DEPTH-1:0] shift_en_o
);

  // A fill takes precedence over a lookup in the same cycle; a fill that
  // already hits only moves the existing entry.
  always_comb begin
    upd_o     = UPD_NONE;
    src_idx_o = lk_idx_i;
    if (fill_vld_i) begin
      src_idx_o = fill_idx_i;
      upd_o     = fill_hit_i ? UPD_REORDER : UPD_INSERT;
    end else if (lk_vld_i && lk_hit_i) begin
      upd_o = UPD_REORDER;
    end
  end

  genvar k;
  generate
    for (k = 0; k < DEPTH; k++) begin : g_en
      localparam logic [IDXW-1:0] POS = IDXW'(k);
      always_comb begin
        unique case (upd_o)
          UPD_INSERT:  shift_en_o[k] = 1'b1;
          UPD_REORDER: shift_en_o[k] = (src_idx_o != '0) && (POS <= src_idx_o);
          default:     shift_en_o[k] = 1'b0;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/shiftlru_icache.sv
module shiftlru_icache
  import lru_icache_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lk_vld_i,
  input  logic [AW-1:0] lk_addr_i,
  input  logic          fill_vld_i,
  input  logic [AW-1:0] fill_addr_i,
  input  logic [DW-1:0] fill_data_i,
  output logic          hit_o,
  output logic [DW-1:0] insn_o
);

  localparam int unsigned IDXW = idx_width(DEPTH);

  // Chain state, stage 0 = most recent
  logic [DEPTH-1:0]          v_q;
  logic [DEPTH-1:0][AW-1:0]  tag_q;
  logic [DEPTH-1:0][DW-1:0]  data_q;

  logic [DEPTH-1:0]          v_d;
  logic [DEPTH-1:0][AW-1:0]  tag_d;
  logic [DEPTH-1:0][DW-1:0]  data_d;
  logic [DEPTH-1:0]          shift_en;

  // Lookup side
  logic [DEPTH-1:0] lk_match;
  logic             lk_hit;
  logic [IDXW-1:0]  lk_idx;
  logic [DW-1:0]    lk_data;

  // Fill side
  logic [DEPTH-1:0] fill_match;
  logic             fill_hit;
  logic [IDXW-1:0]  fill_idx;
  logic [DW-1:0]    fill_old_data;

  upd_e             upd;
  logic [IDXW-1:0]  src_idx;

  lru_icache_match #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW),
    .IDXW  (IDXW)
  ) i_lk_match (
    .addr_i  (lk_addr_i),
    .v_i     (v_q),
    .tag_i   (tag_q),
    .data_i  (data_q),
    .match_o (lk_match),
    .hit_o   (lk_hit),
    .idx_o   (lk_idx),
    .data_o  (lk_data)
  );

  lru_icache_match #(
    .DEPTH (DEPTH),
    .AW    (AW),
    .DW    (DW),
    .IDXW  (IDXW)
  ) i_fill_match (
    .addr_i  (fill_addr_i),
    .v_i     (v_q),
    .tag_i   (tag_q),
    .data_i  (data_q),
    .match_o (fill_match),
    .hit_o   (fill_hit),
    .idx_o   (fill_idx),
    .data_o  (fill_old_data)
  );

  lru_icache_ctrl #(
    .DEPTH (DEPTH),
    .IDXW  (IDXW)
  ) i_ctrl (
    .lk_vld_i   (lk_vld_i),
    .lk_hit_i   (lk_hit),
    .lk_idx_i   (lk_idx),
    .fill_vld_i (fill_vld_i),
    .fill_hit_i (fill_hit),
    .fill_idx_i (fill_idx),
    .upd_o      (upd),
    .src_idx_o  (src_idx),
    .shift_en_o (shift_en)
  );

  // Top stage input: either the new fill or the entry being promoted
  always_comb begin
    if (upd == UPD_INSERT) begin
      v_d[0]    = 1'b1;
      tag_d[0]  = fill_addr_i;
      data_d[0] = fill_data_i;
    end else begin
      v_d[0]    = v_q[src_idx];
      tag_d[0]  = tag_q[src_idx];
      data_d[0] = (fill_vld_i && fill_hit) ? fill_old_data : data_q[src_idx];
    end
  end

  genvar k;
  generate
    for (k = 1; k < DEPTH; k++) begin : g_link
      assign v_d[k]    = v_q[k-1];
      assign tag_d[k]  = tag_q[k-1];
      assign data_d[k] = data_q[k-1];
    end

    for (k = 0; k < DEPTH; k++) begin : g_stage
      lru_icache_stage #(
        .AW (AW),
        .DW (DW)
      ) i_stage (
        .clk      (clk),
        .rst      (rst),
        .en_i     (shift_en[k]),
        .v_d_i    (v_d[k]),
        .tag_d_i  (tag_d[k]),
        .data_d_i (data_d[k]),
        .v_q_o    (v_q[k]),
        .tag_q_o  (tag_q[k]),
        .data_q_o (data_q[k])
      );
    end
  endgenerate

  assign hit_o  = lk_vld_i && lk_hit;
  assign insn_o = hit_o ? lk_data : '0;

endmodule

// File: rtl/lru_icache_chk.sv
module lru_icache_chk #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      lk_vld_i,
  input logic [AW-1:0]             lk_addr_i,
  input logic                      fill_vld_i,
  input logic [AW-1:0]             fill_addr_i,
  input logic [DW-1:0]             fill_data_i,
  input logic                      hit_o,
  input logic [DW-1:0]             insn_o,
  input logic [DEPTH-1:0]          v_q,
  input logic [DEPTH-1:0][AW-1:0]  tag_q,
  input logic [DEPTH-1:0][DW-1:0]  data_q,
  input logic [DEPTH-1:0]          lk_match,
  input logic [DEPTH-1:0]          fill_match
);

  logic fill_new;
  logic fill_old;
  assign fill_new = fill_vld_i && (fill_match == '0);
  assign fill_old = fill_vld_i && (fill_match != '0);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (v_q == '0));

  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    !lk_vld_i |-> (!hit_o && insn_o == '0));

  p_fill_top_r3: assert property (@(posedge clk) disable iff (rst)
    fill_new |=> (v_q[0] && tag_q[0] == $past(fill_addr_i) &&
                  data_q[0] == $past(fill_data_i)));

  p_hit_to_top_r4: assert property (@(posedge clk) disable iff (rst)
    (!fill_vld_i && hit_o) |=> (v_q[0] && tag_q[0] == $past(lk_addr_i) &&
                                data_q[0] == $past(insn_o)));

  p_top_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!fill_vld_i && hit_o && lk_match[0]) |=>
      ($stable(v_q) && $stable(tag_q) && $stable(data_q)));

  p_no_dup_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match) && $onehot0(fill_match));

  p_fill_old_count_r6: assert property (@(posedge clk) disable iff (rst)
    fill_old |=> ($countones(v_q) == $past($countones(v_q))));

  p_count_mono_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ($countones(v_q) >= $past($countones(v_q))));

  generate
    if (DEPTH > 1) begin : g_deep
      p_fill_bottom_r3: assert property (@(posedge clk) disable iff (rst)
        fill_new |=> (v_q[DEPTH-1] == $past(v_q[DEPTH-2]) &&
                      (!v_q[DEPTH-1] || tag_q[DEPTH-1] == $past(tag_q[DEPTH-2]))));

      p_bottom_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (!fill_vld_i && hit_o && !lk_match[DEPTH-1]) |=>
          ($stable(v_q[DEPTH-1]) && $stable(tag_q[DEPTH-1])));
    end
  endgenerate

endmodule

bind shiftlru_icache lru_icache_chk #(
  .DEPTH (DEPTH),
  .AW    (AW),
  .DW    (DW)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .lk_vld_i    (lk_vld_i),
  .lk_addr_i   (lk_addr_i),
  .fill_vld_i  (fill_vld_i),
  .fill_addr_i (fill_addr_i),
  .fill_data_i (fill_data_i),
  .hit_o       (hit_o),
  .insn_o      (insn_o),
  .v_q         (v_q),
  .tag_q       (tag_q),
  .data_q      (data_q),
  .lk_match    (lk_match),
  .fill_match  (fill_match)
);

// File: tb/test_shiftlru_icache.sv
module test_shiftlru_icache;

  localparam int DEPTH = 4;
  localparam int AW    = 32;
  localparam int DW    = 32;
  localparam int POOL  = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          lk_vld_i = 1'b0;
  logic [AW-1:0] lk_addr_i = '0;
  logic          fill_vld_i = 1'b0;
  logic [AW-1:0] fill_addr_i = '0;
  logic [DW-1:0] fill_data_i = '0;
  logic          hit_o;
  logic [DW-1:0] insn_o;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // Reference chain, index 0 = most recent
  bit            m_v    [DEPTH];
  logic [AW-1:0] m_tag  [DEPTH];
  logic [DW-1:0] m_data [DEPTH];

  always #4 clk = ~clk;

  shiftlru_icache #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_shiftlru_icache (
    .clk         (clk),
    .rst         (rst),
    .lk_vld_i    (lk_vld_i),
    .lk_addr_i   (lk_addr_i),
    .fill_vld_i  (fill_vld_i),
    .fill_addr_i (fill_addr_i),
    .fill_data_i (fill_data_i),
    .hit_o       (hit_o),
    .insn_o      (insn_o)
  );

  function automatic logic [AW-1:0] pool_addr(input int i);
    return 32'h0000_1000 + 32'(i) * 32'd4;
  endfunction

  function automatic int m_find(input logic [AW-1:0] a);
    for (int i = 0; i < DEPTH; i++)
      if (m_v[i] && m_tag[i] == a) return i;
    return -1;
  endfunction

  task automatic m_promote(input int k);
    bit            tv = m_v[k];
    logic [AW-1:0] tt = m_tag[k];
    logic [DW-1:0] td = m_data[k];
    for (int i = k; i > 0; i--) begin
      m_v[i] = m_v[i-1]; m_tag[i] = m_tag[i-1]; m_data[i] = m_data[i-1];
    end
    m_v[0] = tv; m_tag[0] = tt; m_data[0] = td;
  endtask

  task automatic m_insert(input logic [AW-1:0] a, input logic [DW-1:0] d);
    for (int i = DEPTH - 1; i > 0; i--) begin
      m_v[i] = m_v[i-1]; m_tag[i] = m_tag[i-1]; m_data[i] = m_data[i-1];
    end
    m_v[0] = 1'b1; m_tag[0] = a; m_data[0] = d;
  endtask

  task automatic check(input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive, compare combinational outputs, clock, update model
  task automatic cyc(input string req, input bit lv, input logic [AW-1:0] la,
                     input bit fv, input logic [AW-1:0] fa, input logic [DW-1:0] fd);
    int k;
    bit eh;
    @(negedge clk);
    lk_vld_i = lv; lk_addr_i = la;
    fill_vld_i = fv; fill_addr_i = fa; fill_data_i = fd;
    #1;
    k  = m_find(la);
    eh = lv && (k >= 0);
    check({req, " hit"}, {{(DW-1){1'b0}}, hit_o}, {{(DW-1){1'b0}}, eh});
    check({req, " insn"}, insn_o, eh ? m_data[k] : '0);
    @(posedge clk);
    if (fv) begin
      int j = m_find(fa);
      if (j >= 0) m_promote(j);
      else        m_insert(fa, fd);
    end else if (eh) begin
      m_promote(k);
    end
  endtask

  task automatic look(input string req, input logic [AW-1:0] a);
    cyc(req, 1'b1, a, 1'b0, '0, '0);
  endtask

  task automatic fill(input string req, input logic [AW-1:0] a, input logic [DW-1:0] d);
    cyc(req, 1'b0, '0, 1'b1, a, d);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0;
    end
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: nothing hits after reset
    for (int i = 0; i < POOL; i++) look("R1 empty", pool_addr(i));

    // R7: partial fills, chain grows one entry at a time
    for (int i = 0; i < DEPTH; i++) begin
      fill("R7 partial fill", pool_addr(i), 32'hA000_0000 + 32'(i));
      look("R7 partial look", pool_addr(0));
    end
    // R2: every cached address hits with its word
    for (int i = 0; i < DEPTH; i++) look("R2 lookup", pool_addr(i));

    // R5: hit on the top entry twice in a row
    look("R5 top hit", pool_addr(DEPTH - 1));
    look("R5 top hit again", pool_addr(DEPTH - 1));

    // R4: hit in the middle, then insert and observe the evicted entry
    look("R4 middle hit", pool_addr(1));
    fill("R3 insert", pool_addr(4), 32'hB000_0004);
    for (int i = 0; i < POOL; i++) look("R3 R4 probe", pool_addr(i));

    // R3: consecutive new fills evict oldest entries
    fill("R3 evict", pool_addr(5), 32'hB000_0005);
    fill("R3 evict", pool_addr(0), 32'hB000_0000);
    for (int i = 0; i < POOL; i++) look("R3 probe", pool_addr(i));

    // R6: fill of a present address keeps old word and only reorders
    fill("R6 refill", pool_addr(0), 32'hDEAD_BEEF);
    look("R6 old word kept", pool_addr(0));
    for (int i = 0; i < POOL; i++) look("R6 probe", pool_addr(i));

    // R8: lookup hit and new fill in the same cycle
    cyc("R8 collide", 1'b1, pool_addr(m_find(pool_addr(2)) >= 0 ? 2 : 3),
        1'b1, 32'h0000_2000, 32'hC0DE_0001);
    for (int i = 0; i < POOL; i++) look("R8 probe", pool_addr(i));
    look("R8 probe new", 32'h0000_2000);

    // R9: idle lookups of present addresses do not reorder
    for (int i = 0; i < POOL; i++)
      cyc("R9 idle", 1'b0, pool_addr(i), 1'b0, '0, '0);
    fill("R9 after idle", 32'h0000_2004, 32'hC0DE_0002);
    for (int i = 0; i < POOL; i++) look("R9 probe", pool_addr(i));

    // Random mix over the address pool
    for (int n = 0; n < 3000; n++) begin
      int r  = int'($urandom_range(0, 99));
      bit lv = (r < 80);
      bit fv = ($urandom_range(0, 99) < 35);
      cyc("R2 R3 R4 R6 R8 random", lv, pool_addr(int'($urandom_range(0, POOL - 1))),
          fv, pool_addr(int'($urandom_range(0, POOL - 1))), $urandom);
    end

    // R1: reset mid-run clears the chain
    @(negedge clk);
    rst = 1'b1; lk_vld_i = 1'b0; fill_vld_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
    for (int i = 0; i < POOL; i++) look("R1 after reset", pool_addr(i));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule